// File: doc/BRIEF.md
# Masked Bus Target

This block sits on a shared multiplexed address/data bus as a responding target with a small word-organised memory behind it. It watches every address phase, assembles either a one-cycle 32-bit address or a two-cycle 64-bit address, and compares the result against a fixed, size-aligned 64-bit window. When the address falls inside the window, it claims the transaction a fixed two cycles after the last address cycle. It then serves a burst of data phases in the direction the command gives.

Writes merge only the bytes selected by the per-byte enable mask into the addressed word. Reads always return the whole 32-bit word. Two parameters narrow the target. With the 64-bit option off, the target ignores any transaction that opens with the two-cycle address command. With bursting off, the target ends every transaction after its first data phase. Within a burst, the word address advances on each completed data phase. The target signals stop on the last word of its window.

Top module: `masked_bus_target`

## Requirements
- R1: A cycle with `addrValid` high and a command other than 4'hD is a one-cycle address phase: the address is `{32'h0, adBus}`. If that address is inside the window, `claim` goes high after exactly two further rising edges, i.e. it is first seen high in the third cycle after the address cycle.
- R2: A cycle with `addrValid` high and command 4'hD (with the 64-bit option on) supplies address bits 31:0 from `adBus`. The following cycle supplies bits 63:32 from `adBus` and the real command from `cmd`. `claim` follows the second cycle with the same two-edge delay as in R1.
- R3: An address outside the window, including one whose low 32 bits alias the window while its high bits differ, never raises `claim`.
- R4: With the 64-bit option off, command 4'hD in an address cycle is ignored together with the cycle that follows it. `claim` stays low even when that following cycle carries an in-window address and a valid command.
- R5: On a write data phase (a cycle with `claim` and `beatValid` high), a memory byte b changes to `adBus[8b+7:8b]` only if `byteEn[b]` is 1. All other bytes of the word keep their value.
- R6: While `claim` is high in a read transaction, `rdData` holds the full current word, whatever `byteEn` is.
- R7: Bit 0 of the final command selects the direction for the whole transaction: 0 means read, 1 means write. Read phases leave the memory unchanged. Memory words are zero after reset.
- R8: The word address starts at the address bits above the byte offset. It advances by one on each completed data phase only; a cycle with `beatValid` low does not advance it.
- R9: With bursting on, `stop` is high exactly while the current word is the last word of the window.
- R10: With bursting off, `stop` is high for the whole time `claim` is high, so only one data phase is served.
- R11: After a completed data phase with `lastBeat` or `stop` high, `claim` and `stop` are low from the next cycle on.
- R12: While `rstN` is low, `claim` and `stop` are forced low on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| addrValid | input | 1 | High on every address cycle |
| adBus | input | 32 | Address during address cycles, write data during data phases |
| cmd | input | 4 | Command; 4'hD opens a two-cycle address, bit 0 gives direction |
| byteEn | input | 4 | Per-byte enable, bit b covers byte b |
| beatValid | input | 1 | Initiator presents a data phase this cycle |
| lastBeat | input | 1 | Initiator marks this data phase as its final one |
| claim | output | 1 | Target owns the current transaction and completes phases |
| stop | output | 1 | Target accepts no phase after the current one |
| rdData | output | 32 | Read word during claimed read transactions, zero otherwise |

## Verification
Two targets share one bus: a 64-bit bursting target placed above 4 GB and a 32-bit-only non-bursting target placed low. Each transaction is therefore also a miss test for the other target. Random write bursts with random byte masks, followed by random reads with random masks, separate correct byte merging from whole-word writes. They also show that reads ignore the mask. Random idle cycles inside bursts show whether the word address advances on phases only. Directed cases cover the following:
- a high-half mismatch that aliases the low window;
- a refused two-cycle address whose second cycle looks like a valid hit;
- a burst that runs into the window's last word;
- a multi-phase request to the non-bursting target.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

  localparam logic [3:0] CMD_DUAL = 4'hD;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIGH,
    ST_SKIP,
    ST_DEC1,
    ST_DEC2,
    ST_DATA
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchLo;   // first address cycle: low half, command, start word
    logic latchHi;   // second address cycle: high half, real command
    logic latchHit;  // register window compare
    logic beatDone;  // a data phase completes this cycle
    logic active;    // transaction owned
  } tgtStrobe_t;

endpackage

// File: rtl/tgt_ctrl.sv
module tgt_ctrl
  import tgt_pkg::*;
#(
  parameter bit DUAL_EN  = 1'b1,
  parameter bit BURST_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrValid,
  input  logic [3:0] cmd,
  input  logic       beatValid,
  input  logic       lastBeat,
  input  logic       hitReg,
  input  logic       atLastWord,
  output tgtStrobe_t stb,
  output logic       claim,
  output logic       stop
);

  tgtState_e state, nextState;
  logic stopInt;

  assign claim   = (state == ST_DATA);
  assign stopInt = claim && (!BURST_EN || atLastWord);
  assign stop    = stopInt;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (addrValid) begin
          if (cmd == CMD_DUAL) begin
            if (DUAL_EN) begin
              stb.latchLo = 1'b1;
              nextState   = ST_HIGH;
            end else begin
              nextState   = ST_SKIP;
            end
          end else begin
            stb.latchLo = 1'b1;
            nextState   = ST_DEC1;
          end
        end
      end
      ST_HIGH: begin
        stb.latchHi = 1'b1;
        nextState   = ST_DEC1;
      end
      ST_SKIP: nextState = ST_IDLE;
      ST_DEC1: begin
        stb.latchHit = 1'b1;
        nextState    = ST_DEC2;
      end
      ST_DEC2: nextState = hitReg ? ST_DATA : ST_IDLE;
      ST_DATA: begin
        stb.active = 1'b1;
        if (beatValid) begin
          stb.beatDone = 1'b1;
          if (lastBeat || stopInt) nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/tgt_dpath.sv
module tgt_dpath
  import tgt_pkg::*;
#(
  parameter logic [63:0] BASE_ADDR = 64'h0000_0001_0000_1000,
  parameter int unsigned MEM_WORDS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  tgtStrobe_t  stb,
  input  logic [31:0] adBus,
  input  logic        cmdWrite,
  input  logic [3:0]  byteEn,
  output logic        hitReg,
  output logic        atLastWord,
  output logic [31:0] rdData
);

  localparam int WORD_BITS = $clog2(MEM_WORDS);
  localparam int ADDR_LSB  = WORD_BITS + 2;
  localparam int BYTES     = 4;
  localparam logic [WORD_BITS-1:0] LAST_WORD = WORD_BITS'(MEM_WORDS - 1);

  logic [31:ADDR_LSB]    addrLoTop;
  logic [31:0]           addrHi;
  logic                  isWrite;
  logic [WORD_BITS-1:0]  wordAddr;
  logic [31:0]           mem [MEM_WORDS];
  logic                  hitNow;

  assign hitNow     = ({addrHi, addrLoTop} == BASE_ADDR[63:ADDR_LSB]);
  assign atLastWord = (wordAddr == LAST_WORD);
  assign rdData     = (stb.active && !isWrite) ? mem[wordAddr] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLoTop <= '0;
      addrHi    <= '0;
      isWrite   <= 1'b0;
      wordAddr  <= '0;
      hitReg    <= 1'b0;
    end else begin
      if (stb.latchLo) begin
        addrLoTop <= adBus[31:ADDR_LSB];
        addrHi    <= '0;
        isWrite   <= cmdWrite;
        wordAddr  <= adBus[ADDR_LSB-1:2];
      end
      if (stb.latchHi) begin
        addrHi  <= adBus;
        isWrite <= cmdWrite;
      end
      if (stb.latchHit) hitReg <= hitNow;
      if (stb.beatDone) wordAddr <= wordAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < MEM_WORDS; w++) mem[w] <= '0;
    end else if (stb.beatDone && isWrite) begin
      for (int b = 0; b < BYTES; b++)
        if (byteEn[b]) mem[wordAddr][8*b +: 8] <= adBus[8*b +: 8];
    end
  end

endmodule

// File: rtl/masked_bus_target.sv
module masked_bus_target
  import tgt_pkg::*;
#(
  parameter logic [63:0] BASE_ADDR = 64'h0000_0001_0000_1000,
  parameter int unsigned MEM_WORDS = 16,
  parameter bit          DUAL_EN   = 1'b1,
  parameter bit          BURST_EN  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrValid,
  input  logic [31:0] adBus,
  input  logic [3:0]  cmd,
  input  logic [3:0]  byteEn,
  input  logic        beatValid,
  input  logic        lastBeat,
  output logic        claim,
  output logic        stop,
  output logic [31:0] rdData
);

  tgtStrobe_t stb;
  logic hitReg;
  logic atLastWord;

  tgt_ctrl #(
    .DUAL_EN (DUAL_EN),
    .BURST_EN(BURST_EN)
  ) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .addrValid (addrValid),
    .cmd       (cmd),
    .beatValid (beatValid),
    .lastBeat  (lastBeat),
    .hitReg    (hitReg),
    .atLastWord(atLastWord),
    .stb       (stb),
    .claim     (claim),
    .stop      (stop)
  );

  tgt_dpath #(
    .BASE_ADDR(BASE_ADDR),
    .MEM_WORDS(MEM_WORDS)
  ) dpathInst (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .adBus     (adBus),
    .cmdWrite  (cmd[0]),
    .byteEn    (byteEn),
    .hitReg    (hitReg),
    .atLastWord(atLastWord),
    .rdData    (rdData)
  );

endmodule

// File: rtl/masked_bus_target_chk.sv
module masked_bus_target_chk
  import tgt_pkg::*;
#(
  parameter bit DUAL_EN  = 1'b1,
  parameter bit BURST_EN = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       addrValid,
  input logic [3:0] cmd,
  input logic       beatValid,
  input logic       lastBeat,
  input logic       claim,
  input logic       stop
);

  AST_CLAIM_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(claim) |-> $past(addrValid, 3)); // R1 R2

  AST_STOP_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    stop |-> claim); // R9

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (claim && beatValid && (lastBeat || stop)) |=> (!claim && !stop)); // R11

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!claim && !stop)); // R12

  generate
    if (!DUAL_EN) begin : gNoDual
      AST_DUAL_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
        (addrValid && cmd == CMD_DUAL && !claim) |-> ##4 !$rose(claim)); // R4
    end
    if (!BURST_EN) begin : gNoBurst
      AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
        claim |-> stop); // R10
    end
  endgenerate

endmodule

bind masked_bus_target masked_bus_target_chk #(
  .DUAL_EN (DUAL_EN),
  .BURST_EN(BURST_EN)
) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .addrValid(addrValid),
  .cmd      (cmd),
  .beatValid(beatValid),
  .lastBeat (lastBeat),
  .claim    (claim),
  .stop     (stop)
);

// File: tb/tb_masked_bus_target.sv
module tb_masked_bus_target;

  localparam logic [63:0] BASE_M  = 64'h0000_0001_0000_1000;
  localparam int          WORDS_M = 16;
  localparam logic [63:0] BASE_L  = 64'h0000_0000_0000_2000;
  localparam int          WORDS_L = 8;
  localparam logic [3:0]  DUALCMD = 4'hD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic [31:0] adBus = '0;
  logic [3:0]  cmd = '0;
  logic [3:0]  byteEn = '0;
  logic        beatValid = 1'b0;
  logic        lastBeat = 1'b0;
  logic        claimM, stopM, claimL, stopL;
  logic [31:0] rdM, rdL;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] refM [WORDS_M];
  logic [31:0] refL [WORDS_L];

  always #4 clk = ~clk;

  masked_bus_target #(
    .BASE_ADDR(BASE_M), .MEM_WORDS(WORDS_M), .DUAL_EN(1'b1), .BURST_EN(1'b1)
  ) dut (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .adBus(adBus), .cmd(cmd),
    .byteEn(byteEn), .beatValid(beatValid), .lastBeat(lastBeat),
    .claim(claimM), .stop(stopM), .rdData(rdM)
  );

  masked_bus_target #(
    .BASE_ADDR(BASE_L), .MEM_WORDS(WORDS_L), .DUAL_EN(1'b0), .BURST_EN(1'b0)
  ) dutLite (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .adBus(adBus), .cmd(cmd),
    .byteEn(byteEn), .beatValid(beatValid), .lastBeat(lastBeat),
    .claim(claimL), .stop(stopL), .rdData(rdL)
  );

  function automatic logic [31:0] mergeBytes(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (m[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic bit expStop(bit lite, int word);
    return lite ? 1'b1 : (word == WORDS_M - 1);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic addrSeq(bit dual, logic [63:0] a, logic [3:0] c);
    @(negedge clk);
    addrValid = 1'b1;
    if (dual) begin
      adBus = a[31:0]; cmd = DUALCMD;
      @(negedge clk);
      adBus = a[63:32]; cmd = c;
    end else begin
      adBus = a[31:0]; cmd = c;
    end
    @(negedge clk);
    addrValid = 1'b0; adBus = '0; cmd = '0;
  endtask

  // called right after addrSeq: claim must appear only after two more edges
  task automatic waitClaim(bit expM, bit expL, string req);
    chk({req, " claim early M"}, claimM, 0);
    chk({req, " claim early L"}, claimL, 0);
    @(negedge clk);
    chk({req, " claim early M"}, claimM, 0);
    chk({req, " claim early L"}, claimL, 0);
    @(negedge clk);
    chk({req, " claim M"}, claimM, expM);
    chk({req, " claim L"}, claimL, expL);
  endtask

  task automatic beats(bit lite, bit wr, int startWord, int n);
    int word = startWord;
    for (int i = 0; i < n; i++) begin
      if ($urandom % 3 == 0) begin
        // idle cycle: no phase, word must not move (R8)
        beatValid = 1'b0; byteEn = 4'($urandom); adBus = $urandom;
        #1;
        chk("R8 idle stop", lite ? stopL : stopM, expStop(lite, word));
        if (!wr) chk("R8 idle rdData", lite ? rdL : rdM, lite ? refL[word] : refM[word]);
        @(negedge clk);
      end
      beatValid = 1'b1;
      byteEn    = 4'($urandom);
      lastBeat  = (i == n - 1);
      adBus     = wr ? $urandom : 32'h0;
      #1;
      chk(lite ? "R10 stop" : "R9 stop", lite ? stopL : stopM, expStop(lite, word));
      if (!wr) chk("R6 R7 read word", lite ? rdL : rdM, lite ? refL[word] : refM[word]);
      @(negedge clk);
      if (wr) begin
        if (lite) refL[word] = mergeBytes(refL[word], adBus, byteEn);
        else      refM[word] = mergeBytes(refM[word], adBus, byteEn);
      end
      if (lastBeat || expStop(lite, word)) begin
        beatValid = 1'b0; lastBeat = 1'b0; adBus = '0;
        chk("R11 release claim", lite ? claimL : claimM, 0);
        chk("R11 release stop", lite ? stopL : stopM, 0);
        break;
      end
      word++;
    end
    beatValid = 1'b0; lastBeat = 1'b0; adBus = '0;
  endtask

  task automatic xfer(bit lite, bit wr, int startWord, int n, string req);
    logic [63:0] a = (lite ? BASE_L : BASE_M) + 64'(startWord * 4);
    logic [3:0]  c = {3'($urandom % 6), wr};
    addrSeq(!lite, a, c);
    waitClaim(!lite, lite, req);
    beats(lite, wr, startWord, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < WORDS_M; w++) refM[w] = '0;
    for (int w = 0; w < WORDS_L; w++) refL[w] = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset claim M", claimM, 0);
    chk("R12 reset stop M", stopM, 0);
    chk("R12 reset claim L", claimL, 0);
    chk("R12 reset stop L", stopL, 0);
    rstN = 1'b1;

    // R7: memory zero after reset, read of whole window
    xfer(1'b0, 1'b0, 0, WORDS_M, "R2 R7 reset read");

    // R3: high half differs, low half aliases the window
    addrSeq(1'b1, 64'h0000_0002_0000_1000, 4'h6);
    waitClaim(1'b0, 1'b0, "R3 high miss");
    // R3: single cycle with low bits of the upper window, high zero
    addrSeq(1'b0, 64'h0000_0000_0000_1004, 4'h7);
    waitClaim(1'b0, 1'b0, "R3 alias miss");

    // R4: refused dual cycle whose second cycle looks like a lite hit
    addrSeq(1'b1, {BASE_L[31:0], BASE_L[31:0]}, 4'h6);
    waitClaim(1'b0, 1'b0, "R4 dual refused");
    @(negedge clk);
    chk("R4 dual refused late", claimL, 0);

    // R5 directed: write all ones under a fixed mask
    addrSeq(1'b1, BASE_M + 64'd8, 4'h7);
    waitClaim(1'b1, 1'b0, "R2 directed");
    beatValid = 1'b1; lastBeat = 1'b1; byteEn = 4'b0101; adBus = 32'hFFFF_FFFF;
    @(negedge clk);
    refM[2] = mergeBytes(refM[2], adBus, byteEn);
    beatValid = 1'b0; lastBeat = 1'b0; adBus = '0;
    xfer(1'b0, 1'b0, 2, 1, "R5 masked write");
    chk("R5 mask expected word", refM[2], 32'h00FF_00FF);

    // R9: burst runs into the last word
    xfer(1'b0, 1'b1, WORDS_M - 2, 4, "R9 end burst");
    xfer(1'b0, 1'b0, WORDS_M - 2, 4, "R9 end burst read");

    // R10: multi-phase request to the non-bursting target
    xfer(1'b1, 1'b1, 2, 3, "R1 R10 single");
    xfer(1'b1, 1'b0, 2, 3, "R1 R10 read");

    // random mix
    for (int t = 0; t < 80; t++) begin
      bit lite = 1'($urandom % 2);
      bit wr   = (t < 30) ? 1'b1 : 1'($urandom % 2);
      int sw   = lite ? int'($urandom % WORDS_L) : int'($urandom % WORDS_M);
      int n    = 1 + int'($urandom % 5);
      xfer(lite, wr, sw, n, lite ? "R1 random" : "R2 random");
    end

    // final sweeps confirm every word
    xfer(1'b0, 1'b0, 0, WORDS_M, "R5 R7 final sweep");
    for (int w = 0; w < WORDS_L; w++) xfer(1'b1, 1'b0, w, 1, "R5 R7 final lite");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule